// File: doc/BRIEF.md
# Waveform Memory Address Sequencer

This block produces the read address for a waveform store made of parallel memory banks, where each address selects one sample word in every bank. While running, it holds each address for 1, 2 or 4 input clocks, depending on the hold factor. It then steps to the next address and returns to address zero after a programmable end address. A one-cycle strobe marks the first clock of every hold period for the converter path that follows.

When stopped, the address stays where it is. A host can then return it to zero, advance it by one, or write a new address into it. Through the same register port, the host reads the current address and the bank words at that address. All host commands that move the address take effect only while the sequencer is stopped. Every such command also restarts the hold period, so the first word after resumption is held for the full time.

Top module: `wfm_addr_seq`

## Requirements
- R1: After reset the address is 0, the sequencer is stopped, `sample_valid` is low, the hold code is 0 and the end address is all ones (register 1 reads all ones).
- R2: Register 0 bits [2:1] hold the hold code: 0 holds each address for 1 clock, 1 for 2 clocks, and 2 or 3 for 4 clocks while running.
- R3: `sample_valid` is high exactly in the first clock of each hold period while running, and low whenever stopped.
- R4: While running, an address equal to or above the end address (register 1) is followed by address 0, and any other address is followed by itself plus one.
- R5: Register 0 bit 0 set to 1 runs the sequencer and set to 0 stops it. Stopping freezes both the address and the hold phase, and running again continues from that same address and phase.
- R6: Writing register 3 with bit 0 set while stopped returns the address to 0. This rewind wins if bit 1 is set in the same write.
- R7: Writing register 3 with bit 1 set and bit 0 clear while stopped advances the address by one, with the wrap rule of R4.
- R8: Writing register 2 while stopped sets the address to the written value.
- R9: Rewind, step and address writes made while running have no effect on the address sequence.
- R10: A rewind, step or address write clears the hold phase, so the next running hold period has its full length and starts with `sample_valid` high.
- R11: Reads are combinational. Register 0 reads {hold code, run} in bits [2:0], register 1 reads the end address, register 2 reads the current address, and register 4+b reads bank b's word at the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 3 | Register index for writes |
| cfg_wdata | input | AW | Write data |
| cfg_raddr | input | 3 | Register index for reads |
| cfg_rdata | output | max(AW,DW) | Read data, zero extended |
| bank_rdata | input | NBANK*DW | Bank words at `mem_addr`, bank 0 in the low bits |
| mem_addr | output | AW | Waveform memory read address |
| sample_valid | output | 1 | First clock of a hold period while running |

## Verification
The bench sweeps every hold code against several end addresses and compares the address and strobe sequence with an expected sample index. It stops and resumes in the middle of hold periods, which catches a design that clears the hold phase on stop or skips an address on resume. It steps across the end address to catch a wrong wrap, and loads an address beyond the end address, which a design testing only for equality would never wrap. Host commands issued while running must not move the address. A step issued just before running must restart a full hold period; a design that kept the stale phase would shorten the first sample.

// File: rtl/wfm_seq_pkg.sv
// Shared definitions for the waveform address sequencer: register
// indices, hold codes and the hold-length decode.
package wfm_seq_pkg;

    localparam int REG_IDX_W = 3;

    localparam logic [REG_IDX_W-1:0] REG_CTRL  = 3'd0;
    localparam logic [REG_IDX_W-1:0] REG_END   = 3'd1;
    localparam logic [REG_IDX_W-1:0] REG_POS   = 3'd2;
    localparam logic [REG_IDX_W-1:0] REG_CMD   = 3'd3;
    localparam int                   BANK_BASE = 4;

    // Width of the hold phase counter (longest hold is 4 clocks).
    localparam int HOLD_CW = 2;

    typedef enum logic [1:0] {
        HOLD_X1  = 2'd0,
        HOLD_X2  = 2'd1,
        HOLD_X4  = 2'd2,
        HOLD_X4R = 2'd3
    } hold_code_e;

    // Host commands that move the address, one strobe each.
    typedef struct packed {
        logic rewind;
        logic step;
        logic load;
    } seq_cmd_t;

    // Last phase index of a hold period for a given code.
    function automatic logic [HOLD_CW-1:0] hold_last(input hold_code_e code);
        case (code)
            HOLD_X1: hold_last = 2'd0;
            HOLD_X2: hold_last = 2'd1;
            default: hold_last = 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/wfm_cfg_regs.sv
// Control register file of the sequencer.
// Holds the run bit, the hold code and the end address, and turns
// writes to the command and position registers into one-cycle strobes.
// Assumes AW >= 3 so that the control fields fit in the write data.
module wfm_cfg_regs
    import wfm_seq_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [REG_IDX_W-1:0] waddr,
    input  logic [AW-1:0]        wdata,
    output logic                 run,
    output hold_code_e           hold_code,
    output logic [AW-1:0]        end_addr,
    output seq_cmd_t             cmd,
    output logic [AW-1:0]        load_val
);

    logic       ctrl_hit;
    logic       end_hit;
    logic       cmd_hit;

    assign ctrl_hit = we && (waddr == REG_CTRL);
    assign end_hit  = we && (waddr == REG_END);
    assign cmd_hit  = we && (waddr == REG_CMD);

    // Control register: run bit and hold code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run       <= 1'b0;
            hold_code <= HOLD_X1;
        end else if (ctrl_hit) begin
            run       <= wdata[0];
            hold_code <= hold_code_e'(wdata[2:1]);
        end
    end

    // End address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_addr <= '1;
        end else if (end_hit) begin
            end_addr <= wdata;
        end
    end

    // Command strobes: rewind has priority over step within one write.
    always_comb begin
        cmd.rewind = cmd_hit && wdata[0];
        cmd.step   = cmd_hit && wdata[1] && !wdata[0];
        cmd.load   = we && (waddr == REG_POS);
    end

    assign load_val = wdata;

endmodule

// File: rtl/wfm_hold_timer.sv
// Hold phase counter.
// Counts clocks within one sample hold while running and flags the last
// one. Stopping freezes the phase. A clear restarts the period at phase 0.
// A phase above a newly shortened hold length ends the period at once.
module wfm_hold_timer
    import wfm_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               clear,
    input  logic [HOLD_CW-1:0] last_idx,
    output logic               advance,
    output logic               phase0
);

    logic [HOLD_CW-1:0] phase;
    logic               at_end;

    assign at_end  = (phase >= last_idx);
    assign advance = run && at_end;
    assign phase0  = (phase == '0);

    // Phase counter: clear, then advance while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (clear) begin
            phase <= '0;
        end else if (run) begin
            phase <= at_end ? '0 : phase + 1'b1;
        end
    end

endmodule

// File: rtl/wfm_addr_ctr.sv
// Waveform address register.
// Applies host commands (already gated to the stopped state) and
// advances while running. Past the end address it returns to zero.
// Priority: rewind, load, step, then advance.
module wfm_addr_ctr #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic          rewind,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] load_val,
    input  logic [AW-1:0] end_addr,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] succ;

    // Successor address with wrap at or beyond the end address.
    always_comb begin
        succ = (addr >= end_addr) ? '0 : addr + 1'b1;
    end

    // Address register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (rewind) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (step || advance) begin
            addr <= succ;
        end
    end

endmodule

// File: rtl/wfm_readback.sv
// Host read multiplexer.
// Returns control state, end address, current address or one bank word
// at the current address. Assumes NBANK <= 4 so that the bank words fit
// the index range.
module wfm_readback
    import wfm_seq_pkg::*;
#(
    parameter int AW    = 10,
    parameter int DW    = 12,
    parameter int NBANK = 4,
    parameter int RD_W  = 12
) (
    input  logic [REG_IDX_W-1:0]  raddr,
    input  logic                  run,
    input  hold_code_e            hold_code,
    input  logic [AW-1:0]         end_addr,
    input  logic [AW-1:0]         addr,
    input  logic [NBANK*DW-1:0]   bank_rdata,
    output logic [RD_W-1:0]       rdata
);

    logic [DW-1:0] words [NBANK];

    // Split the flat bank bus into one word per bank.
    for (genvar b = 0; b < NBANK; b++) begin : g_split
        assign words[b] = bank_rdata[b*DW +: DW];
    end

    // Read select.
    always_comb begin
        rdata = '0;
        case (raddr)
            REG_CTRL: rdata = RD_W'({hold_code, run});
            REG_END:  rdata = RD_W'(end_addr);
            REG_POS:  rdata = RD_W'(addr);
            default: begin
                for (int b = 0; b < NBANK; b++) begin
                    if (raddr == REG_IDX_W'(BANK_BASE + b)) begin
                        rdata = RD_W'(words[b]);
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/wfm_addr_seq.sv
// Waveform memory address sequencer (top).
// Drives the read address of a multi-bank waveform store, holds each
// address for a programmable number of clocks while running, and gives
// a host stop-mode access to rewind, step, load and inspect the memory.
// Assumes AW >= 3 and NBANK <= 4.
module wfm_addr_seq
    import wfm_seq_pkg::*;
#(
    parameter int AW    = 10,
    parameter int DW    = 12,
    parameter int NBANK = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [2:0]                     cfg_waddr,
    input  logic [AW-1:0]                  cfg_wdata,
    input  logic [2:0]                     cfg_raddr,
    output logic [((AW > DW) ? AW : DW)-1:0] cfg_rdata,
    input  logic [NBANK*DW-1:0]            bank_rdata,
    output logic [AW-1:0]                  mem_addr,
    output logic                           sample_valid
);

    localparam int RD_W = (AW > DW) ? AW : DW;

    logic       run;
    hold_code_e hold_code;
    logic [AW-1:0] end_addr;
    seq_cmd_t   cmd;
    seq_cmd_t   cmd_ok;
    logic [AW-1:0] load_val;
    logic       advance;
    logic       phase0;
    logic       hold_clear;

    wfm_cfg_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .waddr     (cfg_waddr),
        .wdata     (cfg_wdata),
        .run       (run),
        .hold_code (hold_code),
        .end_addr  (end_addr),
        .cmd       (cmd),
        .load_val  (load_val)
    );

    // Host commands are honoured only while stopped.
    always_comb begin
        cmd_ok.rewind = cmd.rewind && !run;
        cmd_ok.step   = cmd.step   && !run;
        cmd_ok.load   = cmd.load   && !run;
    end

    assign hold_clear = cmd_ok.rewind || cmd_ok.step || cmd_ok.load;

    wfm_hold_timer u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .clear    (hold_clear),
        .last_idx (hold_last(hold_code)),
        .advance  (advance),
        .phase0   (phase0)
    );

    wfm_addr_ctr #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .rewind   (cmd_ok.rewind),
        .load     (cmd_ok.load),
        .step     (cmd_ok.step),
        .load_val (load_val),
        .end_addr (end_addr),
        .addr     (mem_addr)
    );

    wfm_readback #(.AW(AW), .DW(DW), .NBANK(NBANK), .RD_W(RD_W)) u_rb (
        .raddr      (cfg_raddr),
        .run        (run),
        .hold_code  (hold_code),
        .end_addr   (end_addr),
        .addr       (mem_addr),
        .bank_rdata (bank_rdata),
        .rdata      (cfg_rdata)
    );

    assign sample_valid = run && phase0;

endmodule

// File: rtl/wfm_seq_chk.sv
// Property checker for the sequencer, bound to every instance of the top.
// Observes ports and the run, hold code and end address registers.
module wfm_seq_chk #(
    parameter int AW   = 10,
    parameter int RD_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_we,
    input logic [2:0]      cfg_waddr,
    input logic [AW-1:0]   cfg_wdata,
    input logic [2:0]      cfg_raddr,
    input logic [RD_W-1:0] cfg_rdata,
    input logic [AW-1:0]   mem_addr,
    input logic            sample_valid,
    input logic            run,
    input logic [1:0]      hold_code,
    input logic [AW-1:0]   end_addr
);

    // R1
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |=> (mem_addr == '0 && !sample_valid && !run));

    // R3
    valid_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> run);

    // R5
    stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cfg_we) |=> ($stable(mem_addr) && !sample_valid));

    // R9
    run_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (mem_addr == $past(mem_addr) ||
                 mem_addr == AW'($past(mem_addr) + 1'b1) ||
                 mem_addr == '0));

    // R2
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sample_valid && hold_code != 2'd0 && !cfg_we) |=> $stable(mem_addr));

    // R7
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && cfg_we && cfg_waddr == 3'd3 && cfg_wdata[1:0] == 2'b10) |=>
        (mem_addr == (($past(mem_addr) >= $past(end_addr)) ? '0 :
                      AW'($past(mem_addr) + 1'b1))));

    // R8
    load_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && cfg_we && cfg_waddr == 3'd2) |=> (mem_addr == $past(cfg_wdata)));

    // R11
    pos_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_raddr == 3'd2) |-> (cfg_rdata == RD_W'(mem_addr)));

endmodule

bind wfm_addr_seq wfm_seq_chk #(.AW(AW), .RD_W(RD_W)) u_seq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_waddr    (cfg_waddr),
    .cfg_wdata    (cfg_wdata),
    .cfg_raddr    (cfg_raddr),
    .cfg_rdata    (cfg_rdata),
    .mem_addr     (mem_addr),
    .sample_valid (sample_valid),
    .run          (run),
    .hold_code    (hold_code),
    .end_addr     (end_addr)
);

// File: tb/tb_wfm_addr_seq.sv
// Bench for the sequencer: sweeps hold codes and end addresses with a
// small address width; expected values come from the sample index.
module tb_wfm_addr_seq;

    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int NBANK = 4;
    localparam int RD_W  = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 cfg_we = 1'b0;
    logic [2:0]           cfg_waddr = '0;
    logic [AW-1:0]        cfg_wdata = '0;
    logic [2:0]           cfg_raddr = '0;
    logic [RD_W-1:0]      cfg_rdata;
    logic [NBANK*DW-1:0]  bank_rdata;
    logic [AW-1:0]        mem_addr;
    logic                 sample_valid;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    wfm_addr_seq #(.AW(AW), .DW(DW), .NBANK(NBANK)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_waddr    (cfg_waddr),
        .cfg_wdata    (cfg_wdata),
        .cfg_raddr    (cfg_raddr),
        .cfg_rdata    (cfg_rdata),
        .bank_rdata   (bank_rdata),
        .mem_addr     (mem_addr),
        .sample_valid (sample_valid)
    );

    function automatic logic [DW-1:0] word_of(input int b, input int a);
        return DW'(b * 64 + a * 3 + 5);
    endfunction

    // Memory model: each bank returns a word derived from the address.
    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            bank_rdata[b*DW +: DW] = word_of(b, int'(mem_addr));
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Write one register; called and returning at a falling edge.
    task automatic wr(input int idx, input int d);
        cfg_we    = 1'b1;
        cfg_waddr = 3'(idx);
        cfg_wdata = AW'(d);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic rd(input int idx, output int v);
        cfg_raddr = 3'(idx);
        #1;
        v = int'(cfg_rdata);
    endtask

    // Check the running state at sample index k.
    task automatic obs_run(input int k, input int h, input int lim);
        int ea;
        int v;
        ea = (k / h) % (lim + 1);
        chk("R2/R4 addr", int'(mem_addr), ea);
        chk("R3 valid", int'(sample_valid), (k % h == 0) ? 1 : 0);
        rd(4 + (k % NBANK), v);
        chk("R11 bank", v, int'(word_of(k % NBANK, ea)));
        rd(2, v);
        chk("R11 pos", v, ea);
    endtask

    task automatic obs_stop(input int ea);
        chk("R5 frozen addr", int'(mem_addr), ea);
        chk("R3 valid stopped", int'(sample_valid), 0);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int v;
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 addr", int'(mem_addr), 0);
        chk("R1 valid", int'(sample_valid), 0);
        rd(0, v); chk("R1 ctrl", v, 0);
        rd(1, v); chk("R1 end", v, 15);
        @(negedge clk);

        // Sweep all hold codes against several end addresses.
        for (int c = 0; c < 4; c++) begin
            for (int li = 0; li < 3; li++) begin
                int lim;
                int h;
                lim = (li == 0) ? 2 : (li == 1) ? 5 : 15;
                h   = (c == 0) ? 1 : (c == 1) ? 2 : 4;
                wr(0, c << 1);
                wr(1, lim);
                wr(3, 1);
                rd(0, v); chk("R11 ctrl", v, c << 1);
                rd(1, v); chk("R11 end", v, lim);
                chk("R6 rewind", int'(mem_addr), 0);
                @(negedge clk);
                wr(0, (c << 1) | 1);
                k = 0;
                for (int n = 0; n < 23 + c; n++) begin
                    obs_run(k, h, lim);
                    @(negedge clk);
                    k++;
                end
                wr(0, c << 1);
                k++;
                for (int n = 0; n < 3; n++) begin
                    obs_stop((k / h) % (lim + 1));
                    @(negedge clk);
                end
                wr(0, (c << 1) | 1);
                for (int n = 0; n < 9; n++) begin
                    obs_run(k, h, lim);
                    @(negedge clk);
                    k++;
                end
                wr(0, c << 1);
            end
        end

        // R8 / R7 load and step while stopped, with wrap.
        wr(0, 2 << 1);
        wr(1, 5);
        wr(2, 4);
        chk("R8 load", int'(mem_addr), 4);
        wr(3, 2);
        chk("R7 step", int'(mem_addr), 5);
        wr(3, 2);
        chk("R7 step wrap", int'(mem_addr), 0);
        wr(3, 3);
        chk("R6 rewind wins", int'(mem_addr), 0);

        // R10: step clears a part-used hold period.
        wr(0, (2 << 1) | 1);
        @(negedge clk);
        wr(0, 2 << 1);
        chk("R5 stop mid hold", int'(mem_addr), 0);
        wr(3, 2);
        chk("R7 step", int'(mem_addr), 1);
        wr(0, (2 << 1) | 1);
        for (int n = 0; n < 4; n++) begin
            chk("R10 full hold addr", int'(mem_addr), 1);
            chk("R10 valid", int'(sample_valid), (n == 0) ? 1 : 0);
            @(negedge clk);
        end
        chk("R10 next addr", int'(mem_addr), 2);
        chk("R10 next valid", int'(sample_valid), 1);
        wr(0, 2 << 1);

        // R4 loaded address beyond end address wraps to 0.
        wr(0, 0);
        wr(2, 9);
        wr(0, 1);
        chk("R4 beyond end", int'(mem_addr), 9);
        @(negedge clk);
        chk("R4 beyond end wrap", int'(mem_addr), 0);
        wr(0, 0);

        // R9 commands while running are ignored.
        wr(1, 15);
        wr(3, 1);
        wr(0, 1);
        chk("R9 start", int'(mem_addr), 0);
        wr(3, 1);
        chk("R9 rewind ignored", int'(mem_addr), 1);
        wr(2, 9);
        chk("R9 load ignored", int'(mem_addr), 2);
        wr(3, 2);
        chk("R9 step ignored", int'(mem_addr), 3);
        wr(0, 0);
        chk("R5 stop", int'(mem_addr), 4);
        @(negedge clk);
        chk("R5 stays", int'(mem_addr), 4);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule